// File: doc/BRIEF.md
# Resonant Gate-Drive Timing Sequencer

This block turns one pulse-width-modulated command into the four gating signals of a four-switch resonant gate driver. The switches are a high-side clamp on the power device's gate, a low-side clamp on that gate, and two left-leg switches that steer a small inductor toward the supply or toward ground. Each command edge starts a three-phase timed sequence. The inductor is first precharged while the gate stays clamped. The clamp is then released so the inductor current moves the gate. Finally the opposite clamp engages while the inductor current returns energy to the supply. The left leg switches three times per command edge.

All phase lengths and the left-leg dead time are run-time inputs counted in clock cycles. Phase ends come from counters, not from measurement. The command is synchronised by two flops before edge detection. A new command edge that arrives mid-sequence moves at once to the start of the opposite sequence. This keeps duty cycles near 0 % and 100 % usable. The two left-leg switches never conduct together and the two clamps never conduct together. The high-side clamp and left-leg high switch are P-channel devices, so their outputs are active low.

Top module: `resonant_gate_seq`

## Requirements
- R1: While reset is high and after it is released, with the command low, the outputs hold the idle-off state: `lo_clamp`=1, `leg_lo`=1, `hi_clamp_n`=1 (high clamp off), `leg_hi_n`=1 (left-leg high off). `hi_clamp_n` and `leg_hi_n` are active low; `lo_clamp` and `leg_lo` are active high.
- R2: The first output response to a command edge appears on the fourth rising clock edge after the command changes. Call that edge cycle m=0.
- R3: After a rising command edge, `leg_lo` turns off at m=0 and `leg_hi` turns on at m=`dead_cyc`. `lo_clamp` stays on until m=`pre_cyc` and turns off there.
- R4: At m=`pre_cyc`+`move_cyc` the left-leg high switch turns off and the high clamp turns on. `leg_lo` turns on `dead_cyc` cycles later.
- R5: At m=`pre_cyc`+`move_cyc`+`ret_cyc` `leg_lo` turns off and the left-leg high switch turns on `dead_cyc` cycles later. The high clamp and left-leg high switch then hold unchanged until the next falling command edge.
- R6: A falling command edge runs the mirror sequence with the same timing, with high clamp and low clamp swapped and the two left-leg switches swapped. It ends in the idle-off state of R1.
- R7: The two left-leg switches are never on together. Every left-leg turn-on is preceded by at least `dead_cyc` cycles with both off, and by exactly `dead_cyc` cycles within a sequence.
- R8: The two clamps are never on together. When a forced move swaps them directly, the incoming clamp turns on one cycle after the outgoing one turns off.
- R9: A command edge that arrives before the running sequence ends starts the opposite sequence at once. After an edge seen mid-transition, the outputs follow the new sequence's timing from its m=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Asynchronous gate command, high means power device on |
| pre_cyc | input | CW | Precharge phase length in cycles |
| move_cyc | input | CW | Gate transition phase length in cycles |
| ret_cyc | input | CW | Energy return phase length in cycles |
| dead_cyc | input | CW | Left-leg break-before-make gap in cycles |
| hi_clamp_n | output | 1 | High-side gate clamp, active low |
| leg_hi_n | output | 1 | Left-leg switch to supply, active low |
| lo_clamp | output | 1 | Low-side gate clamp, active high |
| leg_lo | output | 1 | Left-leg switch to ground, active high |

## Verification
The assertions on left-leg spacing assume the timing inputs stay constant during a sequence. They also assume `dead_cyc` is at least 1 and below each phase length. The bench changes timing only while the block rests in a settled clamp state, and every set it applies keeps the dead time under all three phases. Forced-move stimulus is placed at points where the left leg is stable and not inside a dead gap. This gives each expected waveform a single exact answer, which the bench computes from the requirement timing.

// File: rtl/resonant_gate_seq.sv
module resonant_gate_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_in,
  input  logic [CW-1:0] pre_cyc,
  input  logic [CW-1:0] move_cyc,
  input  logic [CW-1:0] ret_cyc,
  input  logic [CW-1:0] dead_cyc,
  output logic          hi_clamp_n,
  output logic          leg_hi_n,
  output logic          lo_clamp,
  output logic          leg_lo
);

  typedef enum logic [2:0] {
    S_OFF, S_RPRE, S_RMOV, S_RRET, S_ON, S_FPRE, S_FMOV, S_FRET
  } st_t;

  logic [2:0] sync_q;
  logic       rise, fall;

  always_ff @(posedge clk)
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pwm_in};

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  st_t           st, st_nx;
  logic [CW-1:0] cnt, len;
  logic          timed, done;

  always_comb
    case (st)
      S_RPRE, S_FPRE: len = pre_cyc;
      S_RMOV, S_FMOV: len = move_cyc;
      default:        len = ret_cyc;
    endcase

  assign timed = st inside {S_RPRE, S_RMOV, S_RRET, S_FPRE, S_FMOV, S_FRET};
  assign done  = timed && (cnt == len - 1'b1);

  always_comb begin
    st_nx = st;
    if (rise)      st_nx = S_RPRE;
    else if (fall) st_nx = S_FPRE;
    else if (done)
      case (st)
        S_RPRE:  st_nx = S_RMOV;
        S_RMOV:  st_nx = S_RRET;
        S_RRET:  st_nx = S_ON;
        S_FPRE:  st_nx = S_FMOV;
        S_FMOV:  st_nx = S_FRET;
        S_FRET:  st_nx = S_OFF;
        default: st_nx = st;
      endcase
  end

  always_ff @(posedge clk)
    if (rst) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st_nx != st || rise || fall) ? '0 : cnt + 1'b1;
    end

  logic want_hc, want_lc, want_lh;
  assign want_hc = st inside {S_RRET, S_ON, S_FPRE};
  assign want_lc = st inside {S_OFF, S_RPRE, S_FRET};
  assign want_lh = st inside {S_RPRE, S_RMOV, S_ON, S_FRET};

  logic hc, lc;
  always_ff @(posedge clk)
    if (rst) begin
      hc <= 1'b0;
      lc <= 1'b1;
    end else begin
      hc <= want_hc & ~lc;
      lc <= want_lc & ~hc;
    end

  logic          lh, ll;
  logic [CW-1:0] dcnt;
  logic          gap_ok;
  assign gap_ok = dcnt >= dead_cyc - 1'b1;

  always_ff @(posedge clk)
    if (rst) begin
      lh   <= 1'b0;
      ll   <= 1'b1;
      dcnt <= '0;
    end else if (want_lh ? ll : lh) begin
      lh   <= 1'b0;
      ll   <= 1'b0;
      dcnt <= '0;
    end else if (!lh && !ll) begin
      if (gap_ok) begin
        lh <= want_lh;
        ll <= ~want_lh;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end

  assign hi_clamp_n = ~hc;
  assign lo_clamp   = lc;
  assign leg_hi_n   = ~lh;
  assign leg_lo     = ll;

  logic [CW-1:0] off_run;
  always_ff @(posedge clk)
    if (rst)                  off_run <= '0;
    else if (!leg_hi_n || leg_lo) off_run <= '0;
    else if (off_run != '1)   off_run <= off_run + 1'b1;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lo_clamp && leg_lo && hi_clamp_n && leg_hi_n));

  p_leg_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!leg_hi_n && leg_lo));

  p_leg_gap_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(!leg_hi_n) || $rose(leg_lo)) |-> off_run >= dead_cyc);

  p_clamp_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!hi_clamp_n && lo_clamp));

  p_lo_after_hi_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_clamp) |-> $past(hi_clamp_n));

  p_hi_after_lo_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_clamp_n) |-> !$past(lo_clamp));

  p_hi_clamp_leg_off_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_clamp_n) |-> leg_hi_n);

  p_lo_clamp_leg_off_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_clamp) |-> !leg_lo);

endmodule

// File: tb/resonant_gate_seq_tb.sv
module resonant_gate_seq_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwm = 1'b0;
  logic [CW-1:0] ta = 8'd4, tb = 8'd6, tc = 8'd5, dt = 8'd2;
  logic          hi_clamp_n, leg_hi_n, lo_clamp, leg_lo;
  int            checks = 0;
  int            fails  = 0;

  always #2 clk = ~clk;

  resonant_gate_seq #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .pwm_in(pwm),
    .pre_cyc(ta), .move_cyc(tb), .ret_cyc(tc), .dead_cyc(dt),
    .hi_clamp_n(hi_clamp_n), .leg_hi_n(leg_hi_n),
    .lo_clamp(lo_clamp), .leg_lo(leg_lo)
  );

  // bit order: {high clamp on, leg high on, low clamp on, leg low on}
  function automatic logic [3:0] model(bit dir, int m, int a, int b, int c, int d);
    logic p, q, r, s;
    p = m >= a + b;
    q = (m >= d && m < a + b) || m >= a + b + c + d;
    r = m < a;
    s = m < 0 || (m >= a + b + d && m < a + b + c);
    return dir ? {p, q, r, s} : {r, s, p, q};
  endfunction

  function automatic logic [3:0] got();
    return {~hi_clamp_n, ~leg_hi_n, lo_clamp, leg_lo};
  endfunction

  task automatic chk(string tag, int m, logic [3:0] exp);
    checks++;
    if (got() !== exp) begin
      fails++;
      $display("FAIL %s at m=%0d: got %b expected %b", tag, m, got(), exp);
    end
  endtask

  task automatic run_edge(bit dir, int mfirst, int mlast, string tag);
    pwm = dir;
    for (int n = 1; n <= mlast + 4; n++) begin
      @(negedge clk);
      if (n - 4 >= mfirst)
        chk(tag, n - 4, model(dir, n - 4, int'(ta), int'(tb), int'(tc), int'(dt)));
    end
  endtask

  task automatic hold(int cyc, logic [3:0] exp, string tag);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(tag, i, exp);
    end
  endtask

  function automatic int full();
    return int'(ta) + int'(tb) + int'(tc) + int'(dt) + 2;
  endfunction

  task automatic t_reset();
    chk("R1 during reset", 0, 4'b0011);
    @(negedge clk);
    rst = 1'b0;
    hold(6, 4'b0011, "R1 after reset");
  endtask

  task automatic t_rise();
    run_edge(1'b1, -3, full(), "R2 R3 R4 R5 R7 rise sequence");
    hold(12, 4'b1100, "R5 hold while on");
  endtask

  task automatic t_fall();
    run_edge(1'b0, -3, full(), "R2 R6 R7 fall sequence");
    hold(8, 4'b0011, "R6 idle after fall");
  endtask

  task automatic t_alt_timing();
    ta = 8'd3; tb = 8'd2; tc = 8'd7; dt = 8'd1;
    run_edge(1'b1, -3, full(), "R3 R4 R5 alt timing rise");
    hold(5, 4'b1100, "R5 alt hold");
    run_edge(1'b0, -3, full(), "R6 alt timing fall");
    hold(5, 4'b0011, "R6 alt idle");
    ta = 8'd4; tb = 8'd6; tc = 8'd5; dt = 8'd2;
  endtask

  task automatic t_abort();
    run_edge(1'b1, -3, 4, "R3 before abort");
    run_edge(1'b0, 0, full(), "R9 abort into fall");
    hold(5, 4'b0011, "R9 idle after abort");
  endtask

  task automatic t_glitch();
    run_edge(1'b1, -3, full(), "R5 rise before glitch");
    hold(4, 4'b1100, "R5 hold before glitch");
    pwm = 1'b0;
    @(negedge clk);
    pwm = 1'b1;
    for (int n = 1; n <= full() + 4; n++) begin
      @(negedge clk);
      if (n == 4)      chk("R8 clamp gap on forced swap", 0, 4'b0000);
      else if (n == 5) chk("R8 R9 low clamp after gap", 1, 4'b0110);
      else if (n > 5)
        chk("R9 rise after glitch", n - 4,
            model(1'b1, n - 4, int'(ta), int'(tb), int'(tc), int'(dt)));
    end
    run_edge(1'b0, -3, full(), "R6 fall after glitch");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_alt_timing();
    t_abort();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-path: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule